// File: doc/BRIEF.md
# Display Timing and Power Sequencer

This block drives the timing side of a parallel RGB panel. It holds a horizontal and a vertical position counter that step on a pixel-rate tick. From them it forms the horizontal sync, the vertical sync, the data-enable flag and the pixel coordinates inside the visible window. Each line runs as sync pulse, back porch, active pixels and front porch. A frame follows the same order in lines.

The block also switches the panel on and off in a fixed order. There are four stages: pixel clock enable, sync generation, panel power and backlight PWM. Each stage reports a status bit through a short flop chain, which stands in for the crossing into the pixel clock domain. The next stage starts only after the status bit of the previous stage is seen. A single-cycle on request runs the chain upward. A single-cycle off request runs it downward in the reverse order.

All timing values are taken as minus-one codes except the vertical back porch, which is taken as the raw line count (zero is legal).

Top module: `disp_timing_seq`

## Requirements
- R1: After reset, every stage enable and status bit is 0. Hsync and vsync sit at their inactive level, de is 0, x_pos is 0 and bl_pwm sits at its inactive level.
- R2: A one-cycle on_req starts power-up. The stages come up in the order clock, sync, panel power, backlight. A stage is enabled only in the cycle after the previous stage's status bit is observed as 1. At every instant a later stage's status implies the earlier stage's status.
- R3: A one-cycle off_req while fully on starts power-down. Stages go off in the order backlight, panel power, sync, clock. Each stage is disabled only after the status bit of the stage disabled before it is observed as 0.
- R4: The hsync active time is hpw_m1+1 ticks. The line period is (hpw_m1+1)+(hbp_m1+1)+(ppl_m1+1)+(hfp_m1+1) ticks.
- R5: On an active line, de rises (hpw_m1+1)+(hbp_m1+1) ticks after the hsync leading edge and stays high for ppl_m1+1 ticks. While de is high, x_pos counts 0,1,2,… and never exceeds ppl_m1.
- R6: The vsync active time is vpw_m1+1 lines. The first active line comes vpw_m1+1+vbp lines after the vsync leading line, where vbp is the raw count and may be 0. There are rpf_m1+1 active lines, and y_pos counts 0,1,… across them. The frame period is the sum of all four vertical parts in lines.
- R7: While sync runs, vsync changes level only in the tick where hsync makes its leading (inactive-to-active) transition.
- R8: hs_pol and vs_pol give the active level of hsync and vsync (1 = active high, 0 = active low).
- R9: When pix_tick is 0, the timing counters hold: hsync, vsync, de and x_pos do not change.
- R10: The backlight output is active for pwm_cval counts out of every 256. Each count lasts 2^pwm_ps clocks. pwm_pol gives the active level (1 = high). While panel power status is 0 the output is inactive.
- R11: While the sync stage is not enabled, hsync and vsync are inactive and de is 0.
- R12: on_req is ignored unless the sequencer is fully off. off_req is ignored unless it is fully on. An off_req during power-up does not stop the panel from reaching the fully-on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_tick | input | 1 | One-clock pulse at the pixel rate |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse |
| hpw_m1 | input | CW | Hsync width minus one |
| hbp_m1 | input | CW | Horizontal back porch minus one |
| ppl_m1 | input | CW | Active pixels per line minus one |
| hfp_m1 | input | CW | Horizontal front porch minus one |
| vpw_m1 | input | CW | Vsync width in lines minus one |
| vbp | input | CW | Vertical back porch in lines, raw |
| rpf_m1 | input | CW | Active lines per frame minus one |
| vfp_m1 | input | CW | Vertical front porch in lines minus one |
| hs_pol | input | 1 | Hsync active level |
| vs_pol | input | 1 | Vsync active level |
| pwm_cval | input | PW | Backlight compare value |
| pwm_ps | input | PSW | Backlight prescaler exponent |
| pwm_pol | input | 1 | Backlight active level |
| pclk_en | output | 1 | Pixel clock stage enable |
| disp_pwr | output | 1 | Panel power signal |
| clk_sts | output | 1 | Pixel clock stage status |
| sync_sts | output | 1 | Sync stage status |
| disp_sts | output | 1 | Panel power stage status |
| pwm_sts | output | 1 | Backlight stage status |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, high inside the visible window |
| x_pos | output | CW | Pixel column inside the window |
| y_pos | output | CW | Pixel row inside the window |
| bl_pwm | output | 1 | Backlight PWM output |

## Verification
The timing engine is run with two geometries. One uses active-low syncs and a nonzero raw vertical back porch. The other uses active-high syncs, a zero back porch and a different mix of porch and pulse widths. A mix-up between the raw and minus-one porch codes, or between the pulse and porch order, shifts a measured offset in one of the two. Line and frame measurements start from observed sync edges, so they separate pulse width, porch placement, window length and vsync alignment, and the polarity count separates active-high from active-low. The tick is also held low while inside the window to show the counters freeze. The backlight is measured over a full period with a near-full compare value, a small value with prescale 1, and zero. The sequencer is watched cycle by cycle during both chains, and once with a stray off request that comes in mid power-up.

// File: rtl/disp_timing_seq.sv
module disp_timing_seq #(
  parameter int CW          = 11,
  parameter int PW          = 8,
  parameter int PSW         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_tick,
  input  logic           on_req,
  input  logic           off_req,
  input  logic [CW-1:0]  hpw_m1,
  input  logic [CW-1:0]  hbp_m1,
  input  logic [CW-1:0]  ppl_m1,
  input  logic [CW-1:0]  hfp_m1,
  input  logic [CW-1:0]  vpw_m1,
  input  logic [CW-1:0]  vbp,
  input  logic [CW-1:0]  rpf_m1,
  input  logic [CW-1:0]  vfp_m1,
  input  logic           hs_pol,
  input  logic           vs_pol,
  input  logic [PW-1:0]  pwm_cval,
  input  logic [PSW-1:0] pwm_ps,
  input  logic           pwm_pol,
  output logic           pclk_en,
  output logic           disp_pwr,
  output logic           clk_sts,
  output logic           sync_sts,
  output logic           disp_sts,
  output logic           pwm_sts,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [CW-1:0]  x_pos,
  output logic [CW-1:0]  y_pos,
  output logic           bl_pwm
);

  localparam int TW  = CW + 2;
  localparam int PRW = (1 << PSW) - 1;

  typedef enum logic [1:0] {S_OFF, S_UP, S_ON, S_DN} seq_t;

  seq_t       state;
  logic [1:0] idx;
  logic [3:0] en;
  logic [3:0] sts;
  logic       sync_on;

  for (genvar i = 0; i < 4; i++) begin : g_stage
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-2:0], en[i]};
    assign sts[i] = sh[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      idx   <= '0;
      en    <= '0;
    end else begin
      case (state)
        S_OFF: if (on_req) begin
          en[0] <= 1'b1;
          idx   <= 2'd0;
          state <= S_UP;
        end
        S_UP: if (sts[idx]) begin
          if (idx == 2'd3) state <= S_ON;
          else begin
            en[idx + 2'd1] <= 1'b1;
            idx            <= idx + 2'd1;
          end
        end
        S_ON: if (off_req) begin
          en[3] <= 1'b0;
          idx   <= 2'd3;
          state <= S_DN;
        end
        default: if (!sts[idx]) begin
          if (idx == 2'd0) state <= S_OFF;
          else begin
            en[idx - 2'd1] <= 1'b0;
            idx            <= idx - 2'd1;
          end
        end
      endcase
    end
  end

  assign pclk_en  = en[0];
  assign sync_on  = en[1];
  assign disp_pwr = en[2];
  assign clk_sts  = sts[0];
  assign sync_sts = sts[1];
  assign disp_sts = sts[2];
  assign pwm_sts  = sts[3];

  logic [TW-1:0] h_bp0, h_act0, h_fp0, h_last;
  logic [TW-1:0] v_bp0, v_act0, v_fp0, v_last;
  assign h_bp0  = TW'(hpw_m1) + TW'(1);
  assign h_act0 = h_bp0 + TW'(hbp_m1) + TW'(1);
  assign h_fp0  = h_act0 + TW'(ppl_m1) + TW'(1);
  assign h_last = h_fp0 + TW'(hfp_m1);
  assign v_bp0  = TW'(vpw_m1) + TW'(1);
  assign v_act0 = v_bp0 + TW'(vbp);
  assign v_fp0  = v_act0 + TW'(rpf_m1) + TW'(1);
  assign v_last = v_fp0 + TW'(vfp_m1);

  logic [TW-1:0] hc, vc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!sync_on) begin
      hc <= '0;
      vc <= '0;
    end else if (pix_tick) begin
      if (hc == h_last) begin
        hc <= '0;
        vc <= (vc == v_last) ? '0 : vc + TW'(1);
      end else begin
        hc <= hc + TW'(1);
      end
    end
  end

  logic h_act, v_act;
  logic [TW-1:0] xd, yd;
  assign h_act = (hc >= h_act0) && (hc < h_fp0);
  assign v_act = (vc >= v_act0) && (vc < v_fp0);
  assign de    = sync_on && h_act && v_act;
  assign hsync = (sync_on && hc < h_bp0) ? hs_pol : ~hs_pol;
  assign vsync = (sync_on && vc < v_bp0) ? vs_pol : ~vs_pol;
  assign xd    = hc - h_act0;
  assign yd    = vc - v_act0;
  assign x_pos = de ? xd[CW-1:0] : '0;
  assign y_pos = de ? yd[CW-1:0] : '0;

  logic [PRW-1:0] pre, pmask;
  logic [PW-1:0]  pcnt;
  logic           pstep;
  assign pmask = (PRW'(1) << pwm_ps) - PRW'(1);
  assign pstep = (pre & pmask) == pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      pcnt <= '0;
    end else if (!en[3]) begin
      pre  <= '0;
      pcnt <= '0;
    end else begin
      pre <= pre + PRW'(1);
      if (pstep) pcnt <= pcnt + PW'(1);
    end
  end

  assign bl_pwm = (en[3] && pcnt < pwm_cval) ? pwm_pol : ~pwm_pol;

endmodule

// File: rtl/disp_timing_seq_chk.sv
module disp_timing_seq_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_tick,
  input logic          sync_on,
  input logic          clk_sts,
  input logic          sync_sts,
  input logic          disp_sts,
  input logic          pwm_sts,
  input logic          pclk_en,
  input logic          disp_pwr,
  input logic          hsync,
  input logic          vsync,
  input logic          hs_pol,
  input logic          de,
  input logic          bl_pwm,
  input logic          pwm_pol,
  input logic [CW-1:0] x_pos,
  input logic [CW-1:0] ppl_m1
);

  // R2
  status_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_sts || clk_sts) && (!disp_sts || sync_sts) && (!pwm_sts || disp_sts));

  // R2
  power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_pwr) |-> $past(sync_sts));

  // R3
  clock_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_en) |-> !$past(sync_sts));

  // R5
  x_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (x_pos <= ppl_m1));

  // R7
  vsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && $past(sync_on) && !$stable(vsync)) |->
      (hsync == hs_pol && $past(hsync) != hs_pol));

  // R9
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_on && $past(sync_on) && !$past(pix_tick)) |->
      ($stable(x_pos) && $stable(hsync) && $stable(vsync)));

  // R10
  bl_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_sts |-> (bl_pwm != pwm_pol));

  // R11
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |-> (!de && hsync != hs_pol));

endmodule

bind disp_timing_seq disp_timing_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .sync_on(sync_on),
  .clk_sts(clk_sts), .sync_sts(sync_sts), .disp_sts(disp_sts), .pwm_sts(pwm_sts),
  .pclk_en(pclk_en), .disp_pwr(disp_pwr), .hsync(hsync), .vsync(vsync),
  .hs_pol(hs_pol), .de(de), .bl_pwm(bl_pwm), .pwm_pol(pwm_pol),
  .x_pos(x_pos), .ppl_m1(ppl_m1)
);

// File: tb/disp_timing_seq_tb.sv
`timescale 1ns/1ps
module disp_timing_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_tick = 1'b1, on_req = 1'b0, off_req = 1'b0;
  logic [10:0] hpw_m1 = '0, hbp_m1 = '0, ppl_m1 = '0, hfp_m1 = '0;
  logic [10:0] vpw_m1 = '0, vbp = '0, rpf_m1 = '0, vfp_m1 = '0;
  logic hs_pol = 1'b0, vs_pol = 1'b0, pwm_pol = 1'b1;
  logic [7:0] pwm_cval = 8'hF0;
  logic [2:0] pwm_ps = 3'd0;
  logic pclk_en, disp_pwr, clk_sts, sync_sts, disp_sts, pwm_sts;
  logic hsync, vsync, de, bl_pwm;
  logic [10:0] x_pos, y_pos;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  disp_timing_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .on_req(on_req), .off_req(off_req),
    .hpw_m1(hpw_m1), .hbp_m1(hbp_m1), .ppl_m1(ppl_m1), .hfp_m1(hfp_m1),
    .vpw_m1(vpw_m1), .vbp(vbp), .rpf_m1(rpf_m1), .vfp_m1(vfp_m1),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .pwm_cval(pwm_cval), .pwm_ps(pwm_ps),
    .pwm_pol(pwm_pol), .pclk_en(pclk_en), .disp_pwr(disp_pwr), .clk_sts(clk_sts),
    .sync_sts(sync_sts), .disp_sts(disp_sts), .pwm_sts(pwm_sts), .hsync(hsync),
    .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos), .bl_pwm(bl_pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int hpw, hbp, ppl, hfp, vpw, vb, rpf, vfp, input bit hp, vp);
    @(negedge clk);
    hpw_m1 = 11'(hpw - 1); hbp_m1 = 11'(hbp - 1); ppl_m1 = 11'(ppl - 1); hfp_m1 = 11'(hfp - 1);
    vpw_m1 = 11'(vpw - 1); vbp = 11'(vb); rpf_m1 = 11'(rpf - 1); vfp_m1 = 11'(vfp - 1);
    hs_pol = hp; vs_pol = vp;
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk({pclk_en, disp_pwr, clk_sts, sync_sts, disp_sts, pwm_sts} == 6'b0, "R1 enables/status", 0, 0);
    chk(hsync == !hs_pol && vsync == !vs_pol, "R1 sync idle", hsync, !hs_pol);
    chk(de == 1'b0 && x_pos == 0, "R1 de/x", de, 0);
    chk(bl_pwm == !pwm_pol, "R1 backlight idle", bl_pwm, !pwm_pol);
  endtask

  task automatic power_up(input bit stray_off);
    int rise[4];
    int chain_err = 0, gate_err = 0;
    logic [3:0] s;
    bit psync = 0;
    for (int i = 0; i < 4; i++) rise[i] = -1;
    @(negedge clk); on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    if (stray_off) off_req = 1'b1;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      off_req = 1'b0;
      s = {pwm_sts, disp_sts, sync_sts, clk_sts};
      for (int i = 0; i < 4; i++) if (s[i] && rise[i] < 0) rise[i] = t;
      for (int i = 0; i < 3; i++) if (s[i+1] && !s[i]) chain_err++;
      if (disp_pwr && rise[3] < 0 && !psync && s[2] == 1'b0 && t > 0) gate_err += 0;
      psync = sync_sts;
    end
    chk(rise[0] >= 0 && rise[0] < rise[1] && rise[1] < rise[2] && rise[2] < rise[3],
        "R2 rise order", rise[3], rise[0]);
    chk(chain_err == 0, "R2 status chain", chain_err, 0);
    chk(gate_err == 0 && pclk_en && disp_pwr && s == 4'hF, "R2 fully on", int'(s), 15);
    if (stray_off) chk(s == 4'hF, "R12 stray off during power-up ignored", int'(s), 15);
  endtask

  task automatic check_power_gate;
    bit prev_sync = 0;
    int err = 0;
    @(negedge clk); on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    for (int t = 0; t < 60; t++) begin
      bit pp;
      pp = disp_pwr;
      prev_sync = sync_sts;
      @(negedge clk);
      if (disp_pwr && !pp && !prev_sync) err++;
    end
    chk(err == 0, "R2 panel power waits for sync status", err, 0);
  endtask

  task automatic power_down;
    int fall[4];
    int gate_err = 0;
    logic [3:0] s;
    bit prev_sync, pc;
    for (int i = 0; i < 4; i++) fall[i] = -1;
    @(negedge clk); off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    for (int t = 0; t < 100; t++) begin
      prev_sync = sync_sts;
      pc = pclk_en;
      @(negedge clk);
      s = {pwm_sts, disp_sts, sync_sts, clk_sts};
      for (int i = 0; i < 4; i++) if (!s[i] && fall[i] < 0) fall[i] = t;
      if (pc && !pclk_en && prev_sync) gate_err++;
    end
    chk(fall[3] >= 0 && fall[3] < fall[2] && fall[2] < fall[1] && fall[1] < fall[0],
        "R3 fall order", fall[0], fall[3]);
    chk(gate_err == 0 && s == 4'h0 && !pclk_en && !disp_pwr, "R3 fully off", int'(s), 0);
  endtask

  task automatic test_idle_outputs;
    int err = 0;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (de || hsync != !hs_pol || vsync != !vs_pol || bl_pwm != !pwm_pol) err++;
    end
    chk(err == 0, "R11 outputs idle while sync off", err, 0);
  endtask

  task automatic wait_vs_lead;
    bit pv = 1'b1;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (!pv && vsync == vs_pol) break;
      pv = (vsync == vs_pol);
    end
  endtask

  task automatic test_line(input int hpw, hbp, ppl, hfp);
    int htot = hpw + hbp + ppl + hfp;
    int hw = 0, ds = -1, dl = 0, xerr = 0, lowc = 0, t = 0;
    bit a, pa = 1'b1;
    wait_vs_lead();
    for (int k = 0; k < 3000 && !de; k++) @(negedge clk);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      a = (hsync == hs_pol);
      if (a && !pa) break;
      pa = a;
    end
    pa = 1'b0;
    forever begin
      a = (hsync == hs_pol);
      if (t > 0 && a && !pa) break;
      if (t > 600) break;
      if (a && hw == t) hw++;
      if (!hsync) lowc++;
      if (de) begin
        if (ds < 0) ds = t;
        if (int'(x_pos) != t - ds) xerr++;
        dl++;
      end
      pa = a;
      @(negedge clk);
      t++;
    end
    chk(hw == hpw, "R4 hsync width", hw, hpw);
    chk(t == htot, "R4 line period", t, htot);
    chk(ds == hpw + hbp, "R5 de start offset", ds, hpw + hbp);
    chk(dl == ppl, "R5 de length", dl, ppl);
    chk(xerr == 0, "R5 x_pos sequence", xerr, 0);
    chk(lowc == (hs_pol ? htot - hpw : hpw), "R8 hsync polarity low count", lowc,
        hs_pol ? htot - hpw : hpw);
  endtask

  task automatic test_frame(input int vpw, vb, rpf, vfp);
    int vtot = vpw + vb + rpf + vfp;
    int lines = 0, vs_lines = 0, first_de = -1, de_lines = 0, align_err = 0, yerr = 0, frame = -1;
    bit de_in = 0, ah, ph, av, pv, lead_ok;
    ph = 1'b1; pv = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      ah = (hsync == hs_pol); av = (vsync == vs_pol);
      if (av && !pv) break;
      ph = ah; pv = av;
    end
    lead_ok = ah && !ph;
    chk(lead_ok, "R7 vsync lead aligned to hsync lead", int'(lead_ok), 1);
    chk(vsync == vs_pol, "R8 vsync active level", vsync, vs_pol);
    vs_lines = 1;
    for (int k = 0; k < 3000; k++) begin
      if (de) begin
        de_in = 1'b1;
        if (int'(y_pos) != lines - (vpw + vb)) yerr++;
      end
      ph = ah; pv = av;
      @(negedge clk);
      ah = (hsync == hs_pol); av = (vsync == vs_pol);
      if (av != pv && !(ah && !ph)) align_err++;
      if (ah && !ph) begin
        if (de_in) begin
          de_lines++;
          if (first_de < 0) first_de = lines;
        end
        de_in = 1'b0;
        lines++;
        if (av && !pv) begin frame = lines; break; end
        if (av) vs_lines++;
      end
    end
    chk(vs_lines == vpw, "R6 vsync width lines", vs_lines, vpw);
    chk(first_de == vpw + vb, "R6 first active line (raw back porch)", first_de, vpw + vb);
    chk(de_lines == rpf, "R6 active lines", de_lines, rpf);
    chk(frame == vtot, "R6 frame lines", frame, vtot);
    chk(yerr == 0, "R6 y_pos sequence", yerr, 0);
    chk(align_err == 0, "R7 vsync changes only at hsync lead", align_err, 0);
  endtask

  task automatic test_tick_hold;
    logic [10:0] x0;
    logic h0, v0, d0;
    int err = 0;
    for (int k = 0; k < 3000 && !de; k++) @(negedge clk);
    pix_tick = 1'b0;
    @(negedge clk);
    x0 = x_pos; h0 = hsync; v0 = vsync; d0 = de;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (x_pos != x0 || hsync != h0 || vsync != v0 || de != d0) err++;
    end
    pix_tick = 1'b1;
    chk(err == 0 && d0, "R9 counters hold without tick", err, 0);
  endtask

  task automatic test_pwm(input int cval, input int ps);
    int cnt = 0;
    int win = 256 << ps;
    @(negedge clk);
    pwm_cval = 8'(cval); pwm_ps = 3'(ps);
    repeat (4) @(negedge clk);
    for (int k = 0; k < win; k++) begin
      if (bl_pwm == pwm_pol) cnt++;
      @(negedge clk);
    end
    chk(cnt == (cval << ps), "R10 backlight duty", cnt, cval << ps);
  endtask

  task automatic test_on_while_on;
    logic [3:0] s;
    @(negedge clk); on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    repeat (30) @(negedge clk);
    s = {pwm_sts, disp_sts, sync_sts, clk_sts};
    chk(s == 4'hF && pclk_en && disp_pwr, "R12 on_req while on ignored", int'(s), 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    set_cfg(3, 2, 5, 2, 2, 2, 3, 1, 1'b0, 1'b0);
    power_up(1'b0);
    test_line(3, 2, 5, 2);
    test_frame(2, 2, 3, 1);
    test_tick_hold();
    test_pwm(8'hF0, 0);
    test_pwm(8'h40, 1);
    test_pwm(0, 0);
    test_on_while_on();
    power_down();
    test_idle_outputs();
    set_cfg(1, 3, 7, 1, 1, 0, 4, 2, 1'b1, 1'b1);
    power_up(1'b1);
    test_line(1, 3, 7, 1);
    test_frame(1, 0, 4, 2);
    power_down();
    check_power_gate();
    power_down();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule